// File: doc/BRIEF.md
# Scanline Table-Driven Transfer Engine

This block moves a few bytes per video line, on up to eight channels, from system memory (the A side) to a byte-addressed peripheral register window (the B side). Each channel walks a list of entries kept in memory. An entry starts with a control byte. Its low seven bits give the number of lines the entry lasts. Its top bit, the repeat flag, says whether every line of the entry transfers or only the first line. The data either follows the control byte in the list (direct) or sits at a 16-bit address held in the list (indirect).

A frame-start pulse loads every enabled channel with its first entry. Each line-start pulse then services the channels that have not yet finished, lowest index first. A channel that reads a control byte of zero stops for the rest of the frame. Its enable bit stays set, so the next frame-start restarts it. While the engine owns a channel it raises that channel's hold flag, which tells the burst copy engine to stop using the channel. Memory reads have one cycle of latency. Every delay below is counted in engine clock cycles.

Top module: `scanline_xfer_engine`

## Requirements
- R1: After reset, `busy_o`, `a_rd_o`, `b_wr_o` and every bit of `hold_o` are 0.
- R2: A frame-start accepted while idle restarts the listed channels. For every channel set in `en_mask_i`, the table pointer is loaded from `cfg_tbl_addr_i`, one control byte is read from {`cfg_tbl_bank_i`, pointer}, and the pointer advances by one. In indirect mode two more bytes are read, low byte first, to form the indirect address. All finished and transfer-pending flags are cleared before this, and every channel loaded this way is left transfer-pending.
- R3: Each serviced line does three things in order. If the channel is transfer-pending it moves one unit. It then decrements the control byte. It then sets transfer-pending to bit 7 of the new value. When bits 6:0 of the new value are zero, the next control byte is read (indirect: plus the address bytes) and the channel becomes transfer-pending.
- R4: The unit is set by `cfg_mode_i`. Code 0 writes 1 byte to dest+0. Code 1 writes 2 bytes to dest+0 and dest+1. Code 2 writes 2 bytes, both to dest+0. Code 3 writes 4 bytes to dest+0 through dest+3.
- R5: In direct mode the data bytes come from {`cfg_tbl_bank_i`, table pointer}. The pointer steps by +1 after each byte, or by -1 when `cfg_decr_i` is set.
- R6: In indirect mode the data bytes come from {`cfg_ind_bank_i`, indirect address}. That address steps by +1 per byte, or by -1 when `cfg_decr_i` is set.
- R7: A control byte of 0x00 finishes the channel. It is no longer serviced in that frame and is serviced again after the next frame-start.
- R8: In indirect mode, a control byte of 0x00 read during a line is followed by a single read. That byte becomes the high byte of the indirect address and the low byte becomes 0x00.
- R9: Within a line, channels are serviced in ascending index order. `busy_o` stays high until the last active channel is done.
- R10: Busy time is fixed by these rules.
  - Frame: 18 cycles, plus 1 final cycle, plus for each enabled channel 1 + 2 per read + 8 (direct) or 24 (indirect).
  - Line: 1 final cycle, plus for each active channel 1 + (16 for the first channel, 8 for the others) + 2 + 2 per byte moved. A reload adds 2 per read, and 16 more when it is indirect.
- R11: An accepted frame-start or line-start sets `hold_o` for every enabled channel. Hold bits clear only on a `burst_clr_i` pulse, and a start in the same cycle wins over the clear.
- R12: Start pulses that arrive while busy are ignored. A line-start with no enabled, unfinished channel causes no activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst_n | input | 1 | Active-low reset |
| frame_start_i | input | 1 | Start-of-frame pulse |
| line_start_i | input | 1 | Start-of-line pulse |
| burst_clr_i | input | 1 | Burst engine restart, clears all hold flags |
| en_mask_i | input | NUM_CH | Per-channel enable |
| cfg_indirect_i | input | NUM_CH | Per-channel indirect data mode |
| cfg_decr_i | input | NUM_CH | Per-channel data address decrement |
| cfg_mode_i | input | NUM_CH x 2 | Per-channel unit code |
| cfg_tbl_addr_i | input | NUM_CH x 16 | Per-channel list start address |
| cfg_tbl_bank_i | input | NUM_CH x 8 | Per-channel list bank |
| cfg_ind_bank_i | input | NUM_CH x 8 | Per-channel indirect data bank |
| cfg_dest_i | input | NUM_CH x 8 | Per-channel B-side base register |
| a_rd_o | output | 1 | A-side read strobe |
| a_addr_o | output | 24 | A-side read address {bank, address} |
| a_rdata_i | input | 8 | A-side read data, one cycle after the strobe |
| b_wr_o | output | 1 | B-side write strobe |
| b_addr_o | output | 8 | B-side register address |
| b_wdata_o | output | 8 | B-side write data |
| hold_o | output | NUM_CH | Per-channel hold flag for the burst engine |
| busy_o | output | 1 | Engine is processing a frame or line start |

## Verification
A start pulse is taken at the first clock edge where it is high while idle. `busy_o` is then high from the next cycle for exactly the cycle count of R10. The bench computes that count, and the expected number of A-side reads, from its own model of the lists. It compares both only after `busy_o` has fallen. Each B-side write is due in the cycle after its A-side read, so a monitor at the falling edge pops the expected address and data as each write strobe appears. The bench checks the hold flags and the idle strobes only between operations, when the engine is settled.

// File: rtl/sl_pkg.sv
package sl_pkg;
    localparam int SL_AW = 16;
    localparam int SL_BANKW = 8;

    typedef enum logic [2:0] {
        ST_IDLE, ST_WAIT, ST_F_SCAN, ST_L_SCAN, ST_L_SVC, ST_RD, ST_CAP, ST_L_UPD
    } sl_state_e;

    typedef enum logic [1:0] {
        TG_CNT, TG_LO, TG_HI, TG_DAT
    } sl_tgt_e;
endpackage

// File: rtl/sl_pick.sv
module sl_pick #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        found_o = |req_i;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/sl_unit.sv
module sl_unit (
    input  logic [1:0] mode_i,
    input  logic [1:0] idx_i,
    output logic [1:0] last_o,
    output logic [1:0] off_o
);
    always_comb begin
        unique case (mode_i)
            2'd0:    begin last_o = 2'd0; off_o = 2'd0;  end
            2'd1:    begin last_o = 2'd1; off_o = idx_i; end
            2'd2:    begin last_o = 2'd1; off_o = 2'd0;  end
            default: begin last_o = 2'd3; off_o = idx_i; end
        endcase
    end
endmodule

// File: rtl/sl_step.sv
module sl_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic         decr_i,
    output logic [W-1:0] y_o
);
    assign y_o = decr_i ? a_i - W'(1) : a_i + W'(1);
endmodule

// File: rtl/scanline_xfer_engine.sv
module scanline_xfer_engine
    import sl_pkg::*;
#(
    parameter int NUM_CH     = 8,
    parameter int WAIT_W     = 8,
    parameter int FRAME_OVH  = 18,
    parameter int DIR_INIT   = 8,
    parameter int IND_INIT   = 24,
    parameter int LINE_OVH   = 8,
    parameter int CH_OVH     = 8,
    parameter int IND_RELOAD = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              frame_start_i,
    input  logic                              line_start_i,
    input  logic                              burst_clr_i,
    input  logic [NUM_CH-1:0]                 en_mask_i,
    input  logic [NUM_CH-1:0]                 cfg_indirect_i,
    input  logic [NUM_CH-1:0]                 cfg_decr_i,
    input  logic [NUM_CH-1:0][1:0]            cfg_mode_i,
    input  logic [NUM_CH-1:0][SL_AW-1:0]      cfg_tbl_addr_i,
    input  logic [NUM_CH-1:0][SL_BANKW-1:0]   cfg_tbl_bank_i,
    input  logic [NUM_CH-1:0][SL_BANKW-1:0]   cfg_ind_bank_i,
    input  logic [NUM_CH-1:0][7:0]            cfg_dest_i,
    output logic                              a_rd_o,
    output logic [SL_BANKW+SL_AW-1:0]         a_addr_o,
    input  logic [7:0]                        a_rdata_i,
    output logic                              b_wr_o,
    output logic [7:0]                        b_addr_o,
    output logic [7:0]                        b_wdata_o,
    output logic [NUM_CH-1:0]                 hold_o,
    output logic                              busy_o
);
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    typedef struct packed {
        sl_state_e                   st;
        sl_state_e                   ret;
        sl_tgt_e                     tgt;
        logic                        frame;
        logic                        first;
        logic [WAIT_W-1:0]           cnt;
        logic [CH_W-1:0]             ch;
        logic [1:0]                  idx;
        logic [NUM_CH-1:0]           scan;
        logic [NUM_CH-1:0]           hold;
        logic [NUM_CH-1:0]           dotx;
        logic [NUM_CH-1:0]           fin;
        logic [NUM_CH-1:0][SL_AW-1:0] tptr;
        logic [NUM_CH-1:0][SL_AW-1:0] iaddr;
        logic [NUM_CH-1:0][7:0]      lcr;
    } eng_t;

    eng_t q, d;

    logic            pk_found;
    logic [CH_W-1:0] pk_idx;
    logic [1:0]      u_last, u_off;
    logic [SL_AW-1:0] st_in, st_out;
    logic [7:0]      nl;
    logic            cur_ind;

    sl_pick #(.N(NUM_CH), .IW(CH_W)) i_pick (
        .req_i(q.scan), .found_o(pk_found), .idx_o(pk_idx)
    );

    sl_unit i_unit (
        .mode_i(cfg_mode_i[q.ch]), .idx_i(q.idx), .last_o(u_last), .off_o(u_off)
    );

    assign cur_ind = cfg_indirect_i[q.ch];
    assign st_in   = cur_ind ? q.iaddr[q.ch] : q.tptr[q.ch];

    sl_step #(.W(SL_AW)) i_step (
        .a_i(st_in), .decr_i(cfg_decr_i[q.ch]), .y_o(st_out)
    );

    always_comb begin
        d         = q;
        a_rd_o    = 1'b0;
        a_addr_o  = '0;
        b_wr_o    = 1'b0;
        b_addr_o  = '0;
        b_wdata_o = '0;
        nl        = q.lcr[q.ch] - 8'd1;
        if (burst_clr_i) d.hold = '0;

        unique case (q.st)
            ST_IDLE: begin
                if (frame_start_i) begin
                    d.frame = 1'b1;
                    d.fin   = '0;
                    d.dotx  = '0;
                    d.scan  = en_mask_i;
                    d.hold  = d.hold | en_mask_i;
                    d.cnt   = WAIT_W'(FRAME_OVH);
                    d.ret   = ST_F_SCAN;
                    d.st    = ST_WAIT;
                end else if (line_start_i && |(en_mask_i & ~q.fin)) begin
                    d.frame = 1'b0;
                    d.first = 1'b1;
                    d.scan  = en_mask_i & ~q.fin;
                    d.hold  = d.hold | en_mask_i;
                    d.st    = ST_L_SCAN;
                end
            end
            ST_WAIT: begin
                if (q.cnt <= WAIT_W'(1)) d.st = q.ret;
                else d.cnt = q.cnt - WAIT_W'(1);
            end
            ST_F_SCAN: begin
                if (pk_found) begin
                    d.ch           = pk_idx;
                    d.scan[pk_idx] = 1'b0;
                    d.tptr[pk_idx] = cfg_tbl_addr_i[pk_idx];
                    d.tgt          = TG_CNT;
                    d.st           = ST_RD;
                end else begin
                    d.st = ST_IDLE;
                end
            end
            ST_L_SCAN: begin
                if (pk_found) begin
                    d.ch           = pk_idx;
                    d.scan[pk_idx] = 1'b0;
                    d.first        = 1'b0;
                    d.cnt          = q.first ? WAIT_W'(LINE_OVH + CH_OVH) : WAIT_W'(CH_OVH);
                    d.ret          = ST_L_SVC;
                    d.st           = ST_WAIT;
                end else begin
                    d.st = ST_IDLE;
                end
            end
            ST_L_SVC: begin
                d.idx = 2'd0;
                if (q.dotx[q.ch]) begin
                    d.tgt = TG_DAT;
                    d.st  = ST_RD;
                end else begin
                    d.st = ST_L_UPD;
                end
            end
            ST_RD: begin
                a_rd_o = 1'b1;
                if (q.tgt == TG_DAT && cur_ind)
                    a_addr_o = {cfg_ind_bank_i[q.ch], q.iaddr[q.ch]};
                else
                    a_addr_o = {cfg_tbl_bank_i[q.ch], q.tptr[q.ch]};
                d.st = ST_CAP;
            end
            ST_CAP: begin
                unique case (q.tgt)
                    TG_CNT: begin
                        d.lcr[q.ch]  = a_rdata_i;
                        d.tptr[q.ch] = q.tptr[q.ch] + SL_AW'(1);
                        d.fin[q.ch]  = (a_rdata_i == 8'h00);
                        if (cur_ind) begin
                            if (!q.frame && a_rdata_i == 8'h00) begin
                                d.iaddr[q.ch][7:0] = 8'h00;
                                d.tgt = TG_HI;
                            end else begin
                                d.tgt = TG_LO;
                            end
                            d.st = ST_RD;
                        end else begin
                            d.dotx[q.ch] = 1'b1;
                            if (q.frame) begin
                                d.cnt = WAIT_W'(DIR_INIT);
                                d.ret = ST_F_SCAN;
                                d.st  = ST_WAIT;
                            end else begin
                                d.st = ST_L_SCAN;
                            end
                        end
                    end
                    TG_LO: begin
                        d.iaddr[q.ch][7:0] = a_rdata_i;
                        d.tptr[q.ch]       = q.tptr[q.ch] + SL_AW'(1);
                        d.tgt              = TG_HI;
                        d.st               = ST_RD;
                    end
                    TG_HI: begin
                        d.iaddr[q.ch][15:8] = a_rdata_i;
                        d.tptr[q.ch]        = q.tptr[q.ch] + SL_AW'(1);
                        d.dotx[q.ch]        = 1'b1;
                        d.cnt = q.frame ? WAIT_W'(IND_INIT) : WAIT_W'(IND_RELOAD);
                        d.ret = q.frame ? ST_F_SCAN : ST_L_SCAN;
                        d.st  = ST_WAIT;
                    end
                    default: begin
                        b_wr_o    = 1'b1;
                        b_addr_o  = cfg_dest_i[q.ch] + {6'd0, u_off};
                        b_wdata_o = a_rdata_i;
                        if (cur_ind) d.iaddr[q.ch] = st_out;
                        else         d.tptr[q.ch]  = st_out;
                        if (q.idx == u_last) begin
                            d.st = ST_L_UPD;
                        end else begin
                            d.idx = q.idx + 2'd1;
                            d.st  = ST_RD;
                        end
                    end
                endcase
            end
            default: begin
                d.lcr[q.ch]  = nl;
                d.dotx[q.ch] = nl[7];
                if (nl[6:0] == 7'd0) begin
                    d.tgt = TG_CNT;
                    d.st  = ST_RD;
                end else begin
                    d.st = ST_L_SCAN;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, ret: ST_IDLE, tgt: TG_CNT, default: '0};
        end else begin
            q <= d;
        end
    end

    assign hold_o = q.hold;
    assign busy_o = (q.st != ST_IDLE);
endmodule

// File: rtl/sl_engine_chk.sv
module sl_engine_chk #(
    parameter int NUM_CH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_start_i,
    input logic              burst_clr_i,
    input logic [NUM_CH-1:0] en_mask_i,
    input logic              a_rd_o,
    input logic              b_wr_o,
    input logic [NUM_CH-1:0] hold_o,
    input logic              busy_o
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!a_rd_o && !b_wr_o));

    // R5
    read_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_rd_o |=> !a_rd_o);

    // R4
    write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_wr_o |-> $past(a_rd_o));

    // R2
    frame_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start_i && !busy_o) |=> busy_o);

    // R11
    hold_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start_i && !busy_o) |=> ((hold_o & $past(en_mask_i)) == $past(en_mask_i)));

    // R11
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !burst_clr_i |=> (($past(hold_o) & ~hold_o) == '0));
endmodule

bind scanline_xfer_engine sl_engine_chk #(.NUM_CH(NUM_CH)) i_chk (
    .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start_i),
    .burst_clr_i(burst_clr_i), .en_mask_i(en_mask_i), .a_rd_o(a_rd_o),
    .b_wr_o(b_wr_o), .hold_o(hold_o), .busy_o(busy_o)
);

// File: tb/test_scanline_xfer_engine.sv
`timescale 1ns/1ps
module test_scanline_xfer_engine;
    localparam int NC = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_start = 1'b0, line_start = 1'b0, burst_clr = 1'b0;
    logic [NC-1:0] en = '0, ind = '0, decr = '0;
    logic [NC-1:0][1:0]  mode = '0;
    logic [NC-1:0][15:0] taddr = '0;
    logic [NC-1:0][7:0]  tbank = '0, ibank = '0, dest = '0;
    logic a_rd, b_wr, busy;
    logic [23:0] a_addr;
    logic [7:0] a_rdata = '0, b_addr, b_wdata;
    logic [NC-1:0] hold;

    always #2.5 clk = ~clk;

    scanline_xfer_engine i_scanline_xfer_engine (
        .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start), .line_start_i(line_start),
        .burst_clr_i(burst_clr), .en_mask_i(en), .cfg_indirect_i(ind), .cfg_decr_i(decr),
        .cfg_mode_i(mode), .cfg_tbl_addr_i(taddr), .cfg_tbl_bank_i(tbank),
        .cfg_ind_bank_i(ibank), .cfg_dest_i(dest), .a_rd_o(a_rd), .a_addr_o(a_addr),
        .a_rdata_i(a_rdata), .b_wr_o(b_wr), .b_addr_o(b_addr), .b_wdata_o(b_wdata),
        .hold_o(hold), .busy_o(busy)
    );

    int checks = 0, fails = 0;
    logic [7:0] tbl [int];

    function automatic logic [7:0] mem_rd(logic [23:0] a);
        if (tbl.exists(int'(a))) return tbl[int'(a)];
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
    endfunction

    always @(posedge clk) if (a_rd) a_rdata <= mem_rd(a_addr);

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // scoreboard of expected B-side writes
    typedef struct packed { logic [7:0] a; logic [7:0] d; } wr_t;
    wr_t exp_q[$];
    int busy_cyc = 0, rd_cnt = 0;

    always @(negedge clk) begin
        if (busy) busy_cyc++;
        if (a_rd) rd_cnt++;
        if (b_wr) begin
            if (exp_q.size() == 0) chk("R9 unexpected write", int'({b_addr, b_wdata}), 0);
            else begin
                wr_t e;
                e = exp_q.pop_front();
                chk("R4/R5/R6/R9 write addr/data", int'({b_addr, b_wdata}), int'({e.a, e.d}));
            end
        end
    end

    // bench model of the channels
    logic [15:0] m_tptr [NC];
    logic [15:0] m_iaddr [NC];
    logic [7:0]  m_lcr [NC];
    logic [NC-1:0] m_dotx = '0, m_fin = '0;

    function automatic int ulen(logic [1:0] m);
        return (m == 2'd0) ? 1 : (m == 2'd3) ? 4 : 2;
    endfunction

    function automatic logic [7:0] uoff(logic [1:0] m, int k);
        return (m == 2'd0 || m == 2'd2) ? 8'd0 : 8'(k);
    endfunction

    function automatic logic [7:0] rd_tbl(int c);
        logic [7:0] v;
        v = mem_rd({tbank[c], m_tptr[c]});
        m_tptr[c] = m_tptr[c] + 16'd1;
        return v;
    endfunction

    task automatic model_frame(output int cyc, output int rds);
        cyc = 18 + 1; rds = 0;
        m_fin = '0; m_dotx = '0;
        for (int c = 0; c < NC; c++) begin
            if (en[c]) begin
                m_tptr[c] = taddr[c];
                m_lcr[c] = rd_tbl(c);
                m_fin[c] = (m_lcr[c] == 8'h00);
                rds++; cyc += 3;
                if (ind[c]) begin
                    m_iaddr[c][7:0] = rd_tbl(c);
                    m_iaddr[c][15:8] = rd_tbl(c);
                    rds += 2; cyc += 4 + 24;
                end else cyc += 8;
                m_dotx[c] = 1'b1;
            end
        end
    endtask

    task automatic model_line(output int cyc, output int rds);
        logic [NC-1:0] act;
        bit first;
        act = en & ~m_fin; first = 1; cyc = 0; rds = 0;
        for (int c = 0; c < NC; c++) begin
            if (act[c]) begin
                cyc += 1 + (first ? 16 : 8) + 2; first = 0;
                if (m_dotx[c]) begin
                    for (int k = 0; k < ulen(mode[c]); k++) begin
                        wr_t w;
                        w.a = dest[c] + uoff(mode[c], k);
                        if (ind[c]) begin
                            w.d = mem_rd({ibank[c], m_iaddr[c]});
                            m_iaddr[c] = decr[c] ? m_iaddr[c] - 16'd1 : m_iaddr[c] + 16'd1;
                        end else begin
                            w.d = mem_rd({tbank[c], m_tptr[c]});
                            m_tptr[c] = decr[c] ? m_tptr[c] - 16'd1 : m_tptr[c] + 16'd1;
                        end
                        exp_q.push_back(w);
                        cyc += 2; rds++;
                    end
                end
                m_lcr[c] = m_lcr[c] - 8'd1;
                m_dotx[c] = m_lcr[c][7];
                if (m_lcr[c][6:0] == 7'd0) begin
                    m_lcr[c] = rd_tbl(c);
                    m_fin[c] = (m_lcr[c] == 8'h00);
                    rds++; cyc += 2;
                    if (ind[c]) begin
                        if (m_lcr[c] == 8'h00) begin
                            m_iaddr[c] = {rd_tbl(c), 8'h00};
                            rds++; cyc += 2;
                        end else begin
                            m_iaddr[c][7:0] = rd_tbl(c);
                            m_iaddr[c][15:8] = rd_tbl(c);
                            rds += 2; cyc += 4;
                        end
                        cyc += 16;
                    end
                    m_dotx[c] = 1'b1;
                end
            end
        end
        if (act != '0) cyc += 1;
    endtask

    task automatic run_op(bit is_frame, bit poke, string req);
        int ecyc, erds;
        if (is_frame) model_frame(ecyc, erds); else model_line(ecyc, erds);
        @(negedge clk);
        busy_cyc = 0; rd_cnt = 0;
        if (is_frame) frame_start = 1'b1; else line_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0; line_start = 1'b0;
        if (poke) begin
            // R12: starts while busy are ignored
            @(negedge clk); frame_start = 1'b1; line_start = 1'b1;
            @(negedge clk); frame_start = 1'b0; line_start = 1'b0;
        end
        while (busy) @(negedge clk);
        chk({req, " R10 busy cycles"}, busy_cyc, ecyc);
        chk({req, " R3/R8 read count"}, rd_cnt, erds);
        chk({req, " R9 pending writes"}, exp_q.size(), 0);
        chk({req, " R11 hold after start"}, int'(hold), int'(en));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // ch0: direct, 2 bytes to dest+0/+1
        taddr[0] = 16'h1000; tbank[0] = 8'h01; dest[0] = 8'h10; mode[0] = 2'd1;
        tbl[24'h011000] = 8'h02; tbl[24'h011001] = 8'h11; tbl[24'h011002] = 8'h12;
        tbl[24'h011003] = 8'h83;
        for (int k = 0; k < 6; k++) tbl[24'h011004 + k] = 8'h20 + 8'(k);
        tbl[24'h01100A] = 8'h00;
        // ch2: indirect, 4 bytes, ends with the one-byte quirk
        taddr[2] = 16'h2000; tbank[2] = 8'h02; ibank[2] = 8'h7E; dest[2] = 8'h20;
        mode[2] = 2'd3; ind[2] = 1'b1;
        tbl[24'h022000] = 8'h81; tbl[24'h022001] = 8'h00; tbl[24'h022002] = 8'h30;
        tbl[24'h022003] = 8'h01; tbl[24'h022004] = 8'h00; tbl[24'h022005] = 8'h40;
        tbl[24'h022006] = 8'h00; tbl[24'h022007] = 8'h50;
        // ch3: direct, single byte, repeat entry
        taddr[3] = 16'h0800; tbank[3] = 8'h04; dest[3] = 8'h30; mode[3] = 2'd0;
        tbl[24'h040800] = 8'h82; tbl[24'h040801] = 8'h61; tbl[24'h040802] = 8'h62;
        tbl[24'h040803] = 8'h00;
        // ch5: indirect, 2 bytes to one register, decrementing
        taddr[5] = 16'h0400; tbank[5] = 8'h03; ibank[5] = 8'h7F; dest[5] = 8'h40;
        mode[5] = 2'd2; ind[5] = 1'b1; decr[5] = 1'b1;
        tbl[24'h030400] = 8'h02; tbl[24'h030401] = 8'h10; tbl[24'h030402] = 8'h80;
        tbl[24'h030403] = 8'h00; tbl[24'h030404] = 8'h90;
        // ch7: configured but never enabled
        taddr[7] = 16'h0000; tbank[7] = 8'h05; dest[7] = 8'h70; mode[7] = 2'd3;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 hold", int'(hold), 0);
        chk("R1 a_rd", int'(a_rd), 0);
        chk("R1 b_wr", int'(b_wr), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after release", int'(busy), 0);

        // R12: line start with nothing enabled does nothing
        run_op(1'b0, 1'b0, "R12 idle line");

        en = 8'b0010_1101;
        run_op(1'b1, 1'b1, "R2 frame");
        for (int l = 0; l < 7; l++) run_op(1'b0, 1'b0, "R3 line");
        // every channel finished: R7 no further service
        chk("R7 all finished", int'(en & ~m_fin), 0);
        run_op(1'b0, 1'b0, "R7 finished line");

        // R11: clear from the burst engine
        @(negedge clk); burst_clr = 1'b1;
        @(negedge clk); burst_clr = 1'b0;
        chk("R11 hold cleared", int'(hold), 0);

        // R7: next frame restarts, with a different enable set
        en = 8'b0010_0101;
        run_op(1'b1, 1'b0, "R7 restart frame");
        for (int l = 0; l < 4; l++) run_op(1'b0, 1'b1, "R9 line");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule